// File: doc/BRIEF.md
# Lazy Forensic Packet Evidence Buffer

This block keeps a bounded first-in first-out history of packet descriptors. Each descriptor is a flow identifier and a packet handle. Every accepted descriptor is written at the head of a circular store. Once the store is at capacity, each new arrival pushes the oldest descriptor out of the tail in the same cycle. Next to the store sits a small fully associative suspicion table. Each entry holds a flow identifier, a packet counter and a bad flag. A watched flow becomes bad when its counter reaches a threshold. A command can also mark a flow bad directly.

Marking a flow bad does not start a search of the store. Each descriptor is tested against the table at the moment it leaves the tail. If its flow is bad, the descriptor is placed on the evidence stream. Otherwise it is discarded. In this way, evidence for a flagged flow drains out in arrival order, one descriptor per eviction, and the buffer holds it until then.

Both streams use valid/ready handshakes. A transfer happens on a rising edge where valid and ready are both high. Once `ev_valid` is raised, it stays high with its data unchanged until `ev_ready` accepts it. Ingress is back-pressured only when all three of these hold:
- the store is full;
- the descriptor at the tail belongs to a bad flow;
- the one evidence slot is occupied and not draining.

This rule ensures that no flagged descriptor is lost. The capacity is a parameter; a deployment sized for about ten seconds of traffic sets it near 100,000.

Top module: `lazy_evidence_buf`

## Requirements
- R1: After a synchronous active-high reset, `occupancy` is 0, `ev_valid` is 0, and the suspicion table is empty, so no flow counts as bad.
- R2: While `occupancy` is below DEPTH, `in_ready` is 1, and each accepted descriptor raises `occupancy` by one after the accepting edge. Without an accepted descriptor, `occupancy` does not change.
- R3: When `occupancy` equals DEPTH, an accepted descriptor evicts the oldest stored descriptor and `occupancy` stays at DEPTH. Descriptors leave in the order they were accepted.
- R4: A descriptor evicted while its flow is bad appears on `ev_flow`/`ev_handle` with `ev_valid` high in the cycle after the accepting edge. It is held stable until accepted by `ev_ready`. A new evidence load in the same cycle as a handshake replaces it with no gap.
- R5: A descriptor evicted while its flow is absent from the table, or present but not bad, produces no evidence.
- R6: A flag command causes no output by itself. Descriptors of that flow that are already stored become evidence only as each one is evicted.
- R7: A watch command (`cmd_flag`=0) allocates an entry with counter 0 for a flow that has none. Each later accepted descriptor of that flow increments the counter. The flow becomes bad when the counter reaches THRESH. A descriptor accepted in the same cycle as its flow's allocation is not counted.
- R8: `in_ready` is 0 exactly when the store is full, the tail descriptor's flow is bad, `ev_valid` is 1 and `ev_ready` is 0. No flagged descriptor is dropped.
- R9: A command for a flow with no entry takes the lowest-index free entry, and is ignored if all N entries are in use. A flag command (`cmd_flag`=1) on a flow with an entry sets its bad flag. A watch command on a flow with an entry changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Ingress descriptor valid |
| in_ready | output | 1 | Ingress may transfer |
| in_flow | input | FLOW_W | Ingress flow identifier |
| in_handle | input | HANDLE_W | Ingress packet handle |
| cmd_valid | input | 1 | Table command strobe |
| cmd_flag | input | 1 | 1: mark flow bad; 0: watch flow |
| cmd_flow | input | FLOW_W | Flow addressed by the command |
| ev_valid | output | 1 | Evidence descriptor valid |
| ev_ready | input | 1 | Evidence consumer ready |
| ev_flow | output | FLOW_W | Evidence flow identifier |
| ev_handle | output | HANDLE_W | Evidence packet handle |
| occupancy | output | $clog2(DEPTH+1) | Descriptors currently stored |

## Verification
A corrupted head or tail pointer is seen only after a delay of one full buffer turnover. It then shows as evidence handles out of arrival order or repeated. An occupancy count that is off shows at once, either as a wrong `occupancy` value or as evictions that start at the wrong fill level. Damaged counter or bad-flag state in the suspicion table stays hidden until the affected flow's oldest descriptor reaches the tail. It then shows as evidence that is missing or extra, or as `in_ready` dropping when it should not. For this reason the bench fills the store and drives at least DEPTH further descriptors after each setup before it counts evidence.

// File: rtl/evb_pkg.sv
package evb_pkg;

  typedef enum logic {
    CMD_WATCH = 1'b0,
    CMD_FLAG  = 1'b1
  } evb_cmd_e;

  // Width of a counter that must reach value lim inclusive.
  function automatic int cnt_width(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

  // Width of an index into n slots (at least one bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/evb_ring.sv
module evb_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 48,
  localparam int PW   = evb_pkg::idx_width(DEPTH),
  localparam int CW   = evb_pkg::cnt_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  tail_q,
  output logic [CW-1:0] count,
  output logic          full
);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] head_ptr, tail_ptr;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full   = (count == CW'(DEPTH));
  assign tail_q = store[tail_ptr];

  always_ff @(posedge clk) begin
    if (push) store[head_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      count    <= '0;
    end else if (push) begin
      head_ptr <= step(head_ptr);
      if (full) tail_ptr <= step(tail_ptr);
      else      count    <= count + CW'(1);
    end
  end

endmodule

// File: rtl/evb_suspect_table.sv
module evb_suspect_table #(
  parameter int N      = 8,
  parameter int FLOW_W = 16,
  parameter int THRESH = 4,
  localparam int IW    = evb_pkg::idx_width(N),
  localparam int TW    = evb_pkg::cnt_width(THRESH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLOW_W-1:0] probe_flow,
  output logic              probe_bad,
  input  logic              pkt_valid,
  input  logic [FLOW_W-1:0] pkt_flow,
  input  logic              cmd_valid,
  input  logic              cmd_flag,
  input  logic [FLOW_W-1:0] cmd_flow
);

  logic [N-1:0]      ent_v, ent_bad;
  logic [FLOW_W-1:0] ent_flow [N];
  logic [TW-1:0]     ent_cnt  [N];

  logic [N-1:0] probe_hit, pkt_hit, cmd_hit;
  logic         any_free, cmd_known;
  logic [IW-1:0] free_idx;

  for (genvar g = 0; g < N; g++) begin : g_match
    assign probe_hit[g] = ent_v[g] && ent_bad[g] && (ent_flow[g] == probe_flow);
    assign pkt_hit[g]   = ent_v[g] && pkt_valid && (ent_flow[g] == pkt_flow);
    assign cmd_hit[g]   = ent_v[g] && (ent_flow[g] == cmd_flow);
  end

  assign probe_bad = |probe_hit;
  assign cmd_known = |cmd_hit;

  // lowest-index free slot wins
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_v[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_entry
    logic alloc_here;
    assign alloc_here = cmd_valid && !cmd_known && any_free && (free_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_v[g]    <= 1'b0;
        ent_bad[g]  <= 1'b0;
        ent_cnt[g]  <= '0;
        ent_flow[g] <= '0;
      end else if (alloc_here) begin
        ent_v[g]    <= 1'b1;
        ent_flow[g] <= cmd_flow;
        ent_cnt[g]  <= '0;
        ent_bad[g]  <= cmd_flag;
      end else begin
        if (pkt_hit[g] && ent_cnt[g] < TW'(THRESH)) begin
          ent_cnt[g] <= ent_cnt[g] + TW'(1);
          if (ent_cnt[g] == TW'(THRESH - 1)) ent_bad[g] <= 1'b1;
        end
        if (cmd_valid && cmd_flag && cmd_hit[g]) ent_bad[g] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/evb_evidence_slot.sv
module evb_evidence_slot #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] dout,
  output logic         can_load
);

  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) dout <= din;
  end

endmodule

// File: rtl/lazy_evidence_buf.sv
module lazy_evidence_buf #(
  parameter int DEPTH    = 16,
  parameter int FLOW_W   = 16,
  parameter int HANDLE_W = 32,
  parameter int N        = 8,
  parameter int THRESH   = 4,
  localparam int DW      = FLOW_W + HANDLE_W,
  localparam int OCW     = evb_pkg::cnt_width(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [FLOW_W-1:0]   in_flow,
  input  logic [HANDLE_W-1:0] in_handle,
  input  logic                cmd_valid,
  input  logic                cmd_flag,
  input  logic [FLOW_W-1:0]   cmd_flow,
  output logic                ev_valid,
  input  logic                ev_ready,
  output logic [FLOW_W-1:0]   ev_flow,
  output logic [HANDLE_W-1:0] ev_handle,
  output logic [OCW-1:0]      occupancy
);

  logic [DW-1:0] tail_desc, ev_desc;
  logic          ring_full, tail_bad, slot_free, accept, ev_load;

  evb_ring #(.DEPTH(DEPTH), .W(DW)) u_ring (
    .clk   (clk),
    .rst   (rst),
    .push  (accept),
    .din   ({in_flow, in_handle}),
    .tail_q(tail_desc),
    .count (occupancy),
    .full  (ring_full)
  );

  evb_suspect_table #(.N(N), .FLOW_W(FLOW_W), .THRESH(THRESH)) u_table (
    .clk       (clk),
    .rst       (rst),
    .probe_flow(tail_desc[DW-1:HANDLE_W]),
    .probe_bad (tail_bad),
    .pkt_valid (accept),
    .pkt_flow  (in_flow),
    .cmd_valid (cmd_valid),
    .cmd_flag  (cmd_flag == evb_pkg::CMD_FLAG),
    .cmd_flow  (cmd_flow)
  );

  evb_evidence_slot #(.W(DW)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .load     (ev_load),
    .din      (tail_desc),
    .out_ready(ev_ready),
    .out_valid(ev_valid),
    .dout     (ev_desc),
    .can_load (slot_free)
  );

  // stall only when an eviction would need a busy evidence slot
  assign in_ready = !ring_full || !tail_bad || slot_free;
  assign accept   = in_valid && in_ready;
  assign ev_load  = accept && ring_full && tail_bad;

  assign ev_flow   = ev_desc[DW-1:HANDLE_W];
  assign ev_handle = ev_desc[HANDLE_W-1:0];

endmodule

// File: rtl/evb_checker.sv
module evb_checker #(
  parameter int DEPTH    = 16,
  parameter int FLOW_W   = 16,
  parameter int HANDLE_W = 32,
  localparam int OCW     = evb_pkg::cnt_width(DEPTH)
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic                ev_valid,
  input logic                ev_ready,
  input logic [FLOW_W-1:0]   ev_flow,
  input logic [HANDLE_W-1:0] ev_handle,
  input logic [OCW-1:0]      occupancy,
  input logic                full,
  input logic                tail_bad
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (occupancy == '0) && !ev_valid);

  p_occ_bound_r2: assert property (@(posedge clk) disable iff (rst)
    occupancy <= OCW'(DEPTH));

  p_ready_not_full_r2: assert property (@(posedge clk) disable iff (rst)
    (occupancy < OCW'(DEPTH)) |-> in_ready);

  p_grow_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && occupancy < OCW'(DEPTH)) |=>
      occupancy == $past(occupancy) + OCW'(1));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(occupancy));

  p_full_stays_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && full) |=> occupancy == OCW'(DEPTH));

  p_ev_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_ready) |=> ev_valid && $stable(ev_flow) && $stable(ev_handle));

  p_no_loss_r8: assert property (@(posedge clk) disable iff (rst)
    (full && tail_bad && ev_valid && !ev_ready) |-> !in_ready);

endmodule

bind lazy_evidence_buf evb_checker #(
  .DEPTH(DEPTH), .FLOW_W(FLOW_W), .HANDLE_W(HANDLE_W)
) u_evb_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .ev_valid (ev_valid),
  .ev_ready (ev_ready),
  .ev_flow  (ev_flow),
  .ev_handle(ev_handle),
  .occupancy(occupancy),
  .full     (ring_full),
  .tail_bad (tail_bad)
);

// File: tb/test_lazy_evidence_buf.sv
`timescale 1ns/1ps
module test_lazy_evidence_buf;

  localparam int DEPTH = 16;
  localparam int FW    = 16;
  localparam int HW    = 32;
  localparam int N     = 8;
  localparam int TH    = 4;
  localparam int OCW   = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, cmd_valid = 1'b0, cmd_flag = 1'b0, ev_ready = 1'b0;
  logic [FW-1:0] in_flow = '0, cmd_flow = '0;
  logic [HW-1:0] in_handle = '0;
  logic in_ready, ev_valid;
  logic [FW-1:0] ev_flow;
  logic [HW-1:0] ev_handle;
  logic [OCW-1:0] occupancy;

  always #2 clk = ~clk;

  lazy_evidence_buf #(.DEPTH(DEPTH), .FLOW_W(FW), .HANDLE_W(HW), .N(N), .THRESH(TH))
  i_lazy_evidence_buf (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_flow(in_flow), .in_handle(in_handle), .cmd_valid(cmd_valid),
    .cmd_flag(cmd_flag), .cmd_flow(cmd_flow), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_flow(ev_flow), .ev_handle(ev_handle),
    .occupancy(occupancy)
  );

  int n_run = 0, n_fail = 0, ev_seen = 0;
  logic [HW-1:0] hseq = '0;

  // reference model
  logic [FW-1:0] qf[$];
  logic [HW-1:0] qh[$];
  bit            mv[N], mb[N];
  logic [FW-1:0] mf[N];
  int            mc[N];
  bit            m_evv;
  logic [FW-1:0] m_evf;
  logic [HW-1:0] m_evh;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_find(input logic [FW-1:0] f);
    for (int i = 0; i < N; i++) if (mv[i] && mf[i] == f) return i;
    return -1;
  endfunction

  function automatic int m_free();
    for (int i = 0; i < N; i++) if (!mv[i]) return i;
    return -1;
  endfunction

  function automatic bit m_bad(input logic [FW-1:0] f);
    int k;
    k = m_find(f);
    return (k >= 0) && mb[k];
  endfunction

  task automatic model_reset();
    qf.delete(); qh.delete();
    for (int i = 0; i < N; i++) begin mv[i] = 0; mb[i] = 0; mc[i] = 0; mf[i] = '0; end
    m_evv = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 0; cmd_valid = 0; ev_ready = 0;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // one clock: check state, drive, predict
  task automatic cyc(input bit iv, input logic [FW-1:0] fl, input bit cv,
                     input bit cf, input logic [FW-1:0] cfl, input bit er);
    bit full_m, tb, exp_rdy, acc;
    int k;
    @(negedge clk);
    check(occupancy == OCW'(qf.size()), (qf.size() == DEPTH) ? "R3 occupancy" : "R2 occupancy",
          occupancy, qf.size());
    check(ev_valid == m_evv, "R4 ev_valid", ev_valid, m_evv);
    if (m_evv && ev_valid) begin
      check(ev_flow == m_evf, "R4 ev_flow", ev_flow, m_evf);
      check(ev_handle == m_evh, "R3 ev_handle order", ev_handle, m_evh);
    end
    in_valid = iv; in_flow = fl; in_handle = hseq;
    cmd_valid = cv; cmd_flag = cf; cmd_flow = cfl; ev_ready = er;
    #1;
    full_m  = (qf.size() == DEPTH);
    tb      = full_m && m_bad(qf[0]);
    exp_rdy = !(tb && m_evv && !er);
    check(in_ready == exp_rdy, "R8 in_ready", in_ready, exp_rdy);
    if (ev_valid && er) ev_seen++;
    acc = iv && exp_rdy;
    if (acc && full_m && tb) begin
      m_evv = 1; m_evf = qf[0]; m_evh = qh[0];
    end else if (er) m_evv = 0;
    if (acc) begin
      if (full_m) begin void'(qf.pop_front()); void'(qh.pop_front()); end
      qf.push_back(fl); qh.push_back(hseq);
      hseq++;
    end
    // table: packet counting on pre-command state, then command
    k = acc ? m_find(fl) : -1;
    if (cv) begin
      int c;
      c = m_find(cfl);
      if (c >= 0) begin
        if (cf) mb[c] = 1;
        if (k >= 0 && k != c && mc[k] < TH) begin mc[k]++; if (mc[k] == TH) mb[k] = 1; end
        else if (k == c && mc[k] < TH) begin mc[k]++; if (mc[k] == TH) mb[k] = 1; end
        k = -1;
      end else begin
        int fr;
        fr = m_free();
        if (k >= 0 && mc[k] < TH) begin mc[k]++; if (mc[k] == TH) mb[k] = 1; end
        k = -1;
        if (fr >= 0) begin mv[fr] = 1; mf[fr] = cfl; mc[fr] = 0; mb[fr] = cf; end
      end
    end
    if (k >= 0 && mc[k] < TH) begin mc[k]++; if (mc[k] == TH) mb[k] = 1; end
  endtask

  task automatic push(input logic [FW-1:0] fl, input int n);
    for (int i = 0; i < n; i++) cyc(1, fl, 0, 0, '0, 1);
  endtask

  task automatic cmd(input bit cf, input logic [FW-1:0] fl);
    cyc(0, '0, 1, cf, fl, 1);
  endtask

  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(occupancy == '0, "R1 occupancy", occupancy, 0);
    check(!ev_valid, "R1 ev_valid", ev_valid, 0);

    // R6/R3/R4: lazy drain of a flagged flow, in order
    push(16'd1, DEPTH);
    cmd(1, 16'd1);
    ev_seen = 0;
    for (int i = 0; i < 3; i++) cyc(0, '0, 0, 0, '0, 1);
    check(ev_seen == 0 && !ev_valid, "R6 no output on flag", ev_seen, 0);
    push(16'd2, DEPTH);
    cyc(0, '0, 0, 0, '0, 1);
    check(ev_seen == DEPTH, "R6 lazy evidence count", ev_seen, DEPTH);
    // R5: unknown flow evicted -> nothing
    ev_seen = 0;
    push(16'd3, DEPTH);
    cyc(0, '0, 0, 0, '0, 1);
    check(ev_seen == 0, "R5 untracked evictions", ev_seen, 0);

    // R7: below threshold stays clean
    do_reset();
    cmd(0, 16'd5);
    push(16'd5, TH - 1); push(16'd6, DEPTH - TH + 1);
    ev_seen = 0;
    push(16'd7, DEPTH); cyc(0, '0, 0, 0, '0, 1);
    check(ev_seen == 0, "R7 below threshold", ev_seen, 0);
    // R7: at threshold the flow turns bad
    do_reset();
    cmd(0, 16'd5);
    push(16'd5, TH); push(16'd6, DEPTH - TH);
    ev_seen = 0;
    push(16'd7, DEPTH); cyc(0, '0, 0, 0, '0, 1);
    check(ev_seen == TH, "R7 threshold reached", ev_seen, TH);

    // R9: table full ignores new flow
    do_reset();
    for (int i = 0; i < N; i++) cmd(0, FW'(10 + i));
    cmd(1, 16'd40);
    push(16'd40, DEPTH);
    ev_seen = 0;
    push(16'd7, DEPTH); cyc(0, '0, 0, 0, '0, 1);
    check(ev_seen == 0, "R9 table full ignored", ev_seen, 0);

    // R8: back-pressure with stalled evidence
    do_reset();
    push(16'd1, DEPTH);
    cmd(1, 16'd1);
    cyc(1, 16'd2, 0, 0, '0, 0);
    cyc(1, 16'd2, 0, 0, '0, 0);
    check(!in_ready, "R8 stall", in_ready, 0);
    check(occupancy == OCW'(DEPTH) && ev_valid, "R8 held", ev_valid, 1);
    cyc(1, 16'd2, 0, 0, '0, 1);
    cyc(1, 16'd2, 0, 0, '0, 1);

    // random phase, model checked every cycle
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      bit iv, cv, cf, er;
      iv = ($urandom_range(0, 99) < 70);
      cv = ($urandom_range(0, 99) < 8);
      cf = ($urandom_range(0, 99) < 30);
      er = ($urandom_range(0, 99) < 65);
      cyc(iv, FW'($urandom_range(0, 11)), cv, cf, FW'($urandom_range(0, 11)), er);
      if (i == 2000) do_reset();
    end
    cyc(0, '0, 0, 0, '0, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule